// File: doc/BRIEF.md
# External-acknowledge bus cycle controller

This block turns single and burst requests from on-chip logic into read and write cycles on an external asynchronous memory-style bus. The bus has an active-low chip enable, an active-low output enable, an active-low write strobe, a 20-bit address and a 32-bit data path. The data path is split into an outgoing word with a drive enable and an incoming word, for a pad ring to merge. The external device sets the length of every beat by pulling an active-low acknowledge line. The controller brings that line into its own clock domain through a two-flop synchronizer. It then recognizes acceptance events from the synchronized level.

Once a read acknowledge is recognized, the controller captures the bus data a fixed number of clocks later and presents it with a one-cycle valid pulse. Once a write acknowledge is recognized, the write strobe is released a fixed number of clocks later, and the write data stays driven for one clock after that. A device may hold acknowledge low for a while. A held acknowledge counts once, up to a limit of three clocks for reads and five for writes. If it is held beyond that limit, it is recognized again and ends the next beat of the burst.

On the internal side, a request is accepted when `req_valid` is high and `req_ready` is high. The request carries the direction, the start address and the burst length. Write data for each beat is fetched through a beat index that the controller publishes.

Top module: `ext_ack_bus_ctrl`

## Requirements
- R1: After reset, `bus_ce_n`, `bus_oe_n` and `bus_we_n` are 1, `bus_doe` and `rd_valid` are 0, and `req_ready` is 1.
- R2: `bus_ack_n` is active low and passes through two synchronizer flops. An acknowledge pin first driven low before clock edge k can be recognized no earlier than the cycle after edge k+1.
- R3: On a read, `bus_din` is captured at the second clock edge after the cycle in which the acknowledge is recognized. It appears on `rd_data`, with `rd_valid` high for exactly that one cycle.
- R4: On a write, `bus_we_n` returns to 1 at the third clock edge after the cycle in which the acknowledge is recognized.
- R5: After `bus_we_n` returns to 1, `bus_doe` stays 1 and `bus_dout` stays unchanged for one more cycle. On the last beat, `bus_doe` then falls to 0.
- R6: Acknowledges are never recognized in two consecutive cycles.
- R7: During a burst read, a synchronized acknowledge held for 1 to 3 cycles counts as one beat. Each further 3 cycles of holding ends one more beat.
- R8: During a burst write, a synchronized acknowledge held for 1 to 5 cycles counts as one beat. Each further 5 cycles of holding ends one more beat.
- R9: The first beat of a request is ended only by a fresh high-to-low transition of the acknowledge. An acknowledge still held from an earlier access, even past chip-enable deassertion and into a new request, causes no recognition.
- R10: Each beat's address is the start address plus 4 times the beat index. `bus_ce_n` stays 0 from acceptance until the last beat completes, then returns to 1. `bus_oe_n` is 0 only on reads and `bus_we_n` only on writes, never both together.
- R11: `req_ready` is 1 only while idle. `req_len` encodes the beat count minus one (0 means 1 beat, 7 means 8 beats). Write data for beat b is sampled from `wr_data` while `wr_beat` equals b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when both high |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 20 | Start address of the access |
| req_len | input | 3 | Beats minus one |
| wr_data | input | 32 | Write data for the beat named by `wr_beat` |
| wr_beat | output | 4 | Index of the next write beat to be loaded |
| rd_data | output | 32 | Captured read data |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write/byte-write strobe, active low |
| bus_addr | output | 20 | Bus address |
| bus_dout | output | 32 | Outgoing bus data |
| bus_doe | output | 1 | Drive enable for `bus_dout` |
| bus_din | input | 32 | Incoming bus data |
| bus_ack_n | input | 1 | External acknowledge, active low, asynchronous |

## Verification
Suppose the acknowledge pin is driven low just before edge k. Then `rd_valid` is due after edge k+3 (two synchronizer flops, then the two-clock capture). `bus_we_n` rises after edge k+4, and `bus_doe` with `bus_ce_n` settles after edge k+5. The bench samples on the falling edge one cycle before and exactly at each of these points, so an early or late result is told apart. For held acknowledges, the bench waits a margin longer than the longest post-acknowledge sequence before comparing the beat count against the arithmetic expectation min(8, 1 + (H-1)/L). It then completes the burst with single pulses.

// File: rtl/eabc_pkg.sv
package eabc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT    = 3'd1,
        ST_RD_DLY  = 3'd2,
        ST_WR_DLY  = 3'd3,
        ST_WR_HOLD = 3'd4
    } seq_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eabc_ack_sync.sv
module eabc_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_pin,
    output logic ack_lvl,
    output logic ack_lvl_prev
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                s_d.chain = ~ack_n_pin;
                s_d.prev  = s_q.chain[0];
            end
        end else begin : g_multi
            always_comb begin
                s_d.chain = {s_q.chain[STAGES-2:0], ~ack_n_pin};
                s_d.prev  = s_q.chain[STAGES-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ack_lvl      = s_q.chain[STAGES-1];
    assign ack_lvl_prev = s_q.prev;
endmodule

// File: rtl/eabc_ack_detect.sv
module eabc_ack_detect #(
    parameter int RD_HOLD_LIM = 3,
    parameter int WR_HOLD_LIM = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_lvl,
    input  logic ack_lvl_prev,
    input  logic window,
    input  logic first_beat,
    input  logic is_write,
    output logic ack_hit
);
    localparam int CNT_MAX = eabc_pkg::max_of(RD_HOLD_LIM, WR_HOLD_LIM);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hit;
    } det_t;

    det_t d_d, d_q;
    logic [CNT_W-1:0] limit;
    logic             fresh;
    logic             rehit;

    always_comb begin
        limit   = is_write ? CNT_W'(WR_HOLD_LIM) : CNT_W'(RD_HOLD_LIM);
        fresh   = ack_lvl && !ack_lvl_prev;
        rehit   = ack_lvl && !first_beat && (d_q.cnt == limit);
        ack_hit = window && !d_q.hit && (fresh || rehit);

        d_d.hit = ack_hit;
        if (!ack_lvl)                       d_d.cnt = '0;
        else if (ack_hit)                   d_d.cnt = CNT_W'(1);
        else if (d_q.cnt < CNT_W'(CNT_MAX)) d_d.cnt = d_q.cnt + CNT_W'(1);
        else                                d_d.cnt = d_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end
endmodule

// File: rtl/eabc_sequencer.sv
module eabc_sequencer #(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 32,
    parameter int MAX_BEATS  = 8,
    parameter int WORD_BYTES = 4,
    parameter int RD_LAT     = 2,
    parameter int WR_STB_LAT = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [$clog2(MAX_BEATS)-1:0] req_len,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [$clog2(MAX_BEATS+1)-1:0] wr_beat,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rd_valid,
    input  logic                         ack_hit,
    output logic                         window,
    output logic                         first_beat,
    output logic                         is_write,
    output logic                         bus_ce_n,
    output logic                         bus_oe_n,
    output logic                         bus_we_n,
    output logic [ADDR_W-1:0]            bus_addr,
    output logic [DATA_W-1:0]            bus_dout,
    output logic                         bus_doe,
    input  logic [DATA_W-1:0]            bus_din
);
    import eabc_pkg::*;

    localparam int LEN_W   = $clog2(MAX_BEATS);
    localparam int IDX_W   = $clog2(MAX_BEATS + 1);
    localparam int DLY_MAX = max_of(RD_LAT, WR_STB_LAT);
    localparam int DLY_W   = $clog2(DLY_MAX + 1);
    localparam logic [DLY_W-1:0] RD_LAST = DLY_W'(RD_LAT - 2);
    localparam logic [DLY_W-1:0] WR_LAST = DLY_W'(WR_STB_LAT - 2);

    typedef struct packed {
        seq_state_e        state;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
        logic              first;
        logic [IDX_W-1:0]  nidx;
        logic [DLY_W-1:0]  dly;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [DATA_W-1:0] dout;
        logic              doe;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state  = ST_WAIT;
                    r_d.write  = req_write;
                    r_d.addr   = req_addr;
                    r_d.remain = req_len;
                    r_d.first  = 1'b1;
                    r_d.ce_n   = 1'b0;
                    r_d.oe_n   = req_write;
                    r_d.we_n   = !req_write;
                    r_d.doe    = req_write;
                    r_d.dly    = '0;
                    if (req_write) begin
                        r_d.dout = wr_data;
                        r_d.nidx = r_q.nidx + IDX_W'(1);
                    end
                end
            end
            ST_WAIT: begin
                if (ack_hit) begin
                    r_d.dly   = '0;
                    r_d.state = r_q.write ? ST_WR_DLY : ST_RD_DLY;
                end
            end
            ST_RD_DLY: begin
                if (r_q.dly == RD_LAST) begin
                    r_d.rdata  = bus_din;
                    r_d.rvalid = 1'b1;
                    if (r_q.remain == '0) begin
                        r_d.state = ST_IDLE;
                        r_d.ce_n  = 1'b1;
                        r_d.oe_n  = 1'b1;
                    end else begin
                        r_d.state  = ST_WAIT;
                        r_d.addr   = r_q.addr + ADDR_W'(WORD_BYTES);
                        r_d.remain = r_q.remain - LEN_W'(1);
                        r_d.first  = 1'b0;
                    end
                end else begin
                    r_d.dly = r_q.dly + DLY_W'(1);
                end
            end
            ST_WR_DLY: begin
                if (r_q.dly == WR_LAST) begin
                    r_d.we_n  = 1'b1;
                    r_d.state = ST_WR_HOLD;
                end else begin
                    r_d.dly = r_q.dly + DLY_W'(1);
                end
            end
            ST_WR_HOLD: begin
                if (r_q.remain == '0) begin
                    r_d.state = ST_IDLE;
                    r_d.ce_n  = 1'b1;
                    r_d.doe   = 1'b0;
                    r_d.nidx  = '0;
                end else begin
                    r_d.state  = ST_WAIT;
                    r_d.addr   = r_q.addr + ADDR_W'(WORD_BYTES);
                    r_d.remain = r_q.remain - LEN_W'(1);
                    r_d.first  = 1'b0;
                    r_d.we_n   = 1'b0;
                    r_d.dout   = wr_data;
                    r_d.nidx   = r_q.nidx + IDX_W'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.ce_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.state == ST_IDLE);
    assign window     = (r_q.state == ST_WAIT);
    assign first_beat = r_q.first;
    assign is_write   = r_q.write;
    assign wr_beat    = r_q.nidx;
    assign rd_data    = r_q.rdata;
    assign rd_valid   = r_q.rvalid;
    assign bus_ce_n   = r_q.ce_n;
    assign bus_oe_n   = r_q.oe_n;
    assign bus_we_n   = r_q.we_n;
    assign bus_addr   = r_q.addr;
    assign bus_dout   = r_q.dout;
    assign bus_doe    = r_q.doe;
endmodule

// File: rtl/ext_ack_bus_ctrl.sv
module ext_ack_bus_ctrl #(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 32,
    parameter int MAX_BEATS   = 8,
    parameter int WORD_BYTES  = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RD_LAT      = 2,
    parameter int WR_STB_LAT  = 3,
    parameter int RD_HOLD_LIM = 3,
    parameter int WR_HOLD_LIM = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [$clog2(MAX_BEATS)-1:0]   req_len,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [$clog2(MAX_BEATS+1)-1:0] wr_beat,
    output logic [DATA_W-1:0]              rd_data,
    output logic                           rd_valid,
    output logic                           bus_ce_n,
    output logic                           bus_oe_n,
    output logic                           bus_we_n,
    output logic [ADDR_W-1:0]              bus_addr,
    output logic [DATA_W-1:0]              bus_dout,
    output logic                           bus_doe,
    input  logic [DATA_W-1:0]              bus_din,
    input  logic                           bus_ack_n
);
    logic ack_lvl, ack_lvl_prev;
    logic ack_hit;
    logic seq_window, seq_first, seq_write;

    eabc_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_n_pin    (bus_ack_n),
        .ack_lvl      (ack_lvl),
        .ack_lvl_prev (ack_lvl_prev)
    );

    eabc_ack_detect #(
        .RD_HOLD_LIM (RD_HOLD_LIM),
        .WR_HOLD_LIM (WR_HOLD_LIM)
    ) u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_lvl      (ack_lvl),
        .ack_lvl_prev (ack_lvl_prev),
        .window       (seq_window),
        .first_beat   (seq_first),
        .is_write     (seq_write),
        .ack_hit      (ack_hit)
    );

    eabc_sequencer #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .MAX_BEATS  (MAX_BEATS),
        .WORD_BYTES (WORD_BYTES),
        .RD_LAT     (RD_LAT),
        .WR_STB_LAT (WR_STB_LAT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .wr_data    (wr_data),
        .wr_beat    (wr_beat),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .ack_hit    (ack_hit),
        .window     (seq_window),
        .first_beat (seq_first),
        .is_write   (seq_write),
        .bus_ce_n   (bus_ce_n),
        .bus_oe_n   (bus_oe_n),
        .bus_we_n   (bus_we_n),
        .bus_addr   (bus_addr),
        .bus_dout   (bus_dout),
        .bus_doe    (bus_doe),
        .bus_din    (bus_din)
    );
endmodule

// File: rtl/eabc_checker.sv
module eabc_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_ack_n,
    input logic ack_hit,
    input logic is_write,
    input logic rd_valid,
    input logic bus_ce_n,
    input logic bus_oe_n,
    input logic bus_we_n,
    input logic bus_doe
);
    a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |-> !$past(bus_ack_n, 2));

    a_r3_read_latch: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(ack_hit, 2) && !$past(is_write, 2)));

    a_r4_strobe_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we_n) |-> $past(ack_hit, 3));

    a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_doe) |-> ($past(bus_we_n) && !$past(bus_we_n, 2)));

    a_r6_no_double: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> !ack_hit);

    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n));

    a_r10_ce_gates: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ce_n |-> (bus_oe_n && bus_we_n));
endmodule

bind ext_ack_bus_ctrl eabc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ack_n (bus_ack_n),
    .ack_hit   (ack_hit),
    .is_write  (seq_write),
    .rd_valid  (rd_valid),
    .bus_ce_n  (bus_ce_n),
    .bus_oe_n  (bus_oe_n),
    .bus_we_n  (bus_we_n),
    .bus_doe   (bus_doe)
);

// File: tb/ext_ack_bus_ctrl_bench.sv
module ext_ack_bus_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [2:0]  req_len = '0;
    logic [31:0] wr_data;
    logic [3:0]  wr_beat;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        bus_ce_n, bus_oe_n, bus_we_n, bus_doe;
    logic [19:0] bus_addr;
    logic [31:0] bus_dout, bus_din;
    logic        bus_ack_n = 1'b1;

    logic [7:0]  tag = '0;
    int          errors = 0;
    int          checks = 0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [19:0] exp_raddr = '0;
    logic [19:0] exp_waddr = '0;
    logic        prev_rv = 1'b0;
    logic        prev_we = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign wr_data = {8'hC3, tag, 12'h000, wr_beat};
    assign bus_din = {12'hD5A, bus_addr};

    ext_ack_bus_ctrl u_ext_ack_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_beat(wr_beat), .rd_data(rd_data), .rd_valid(rd_valid),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_ack_n(bus_ack_n)
    );

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // bus monitor: read data, write data, addresses, spacing of events
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                check(rd_data == {12'hD5A, exp_raddr}, "R3 read data", rd_data, {12'hD5A, exp_raddr});
                check(!prev_rv, "R6 recognitions not back to back (read)", prev_rv, 0);
                exp_raddr = exp_raddr + 20'd4;
                rd_cnt++;
            end
            if (!prev_we && bus_we_n) begin
                check(bus_dout == {8'hC3, tag, 12'h000, 4'(wr_cnt)}, "R11 write data per beat",
                      bus_dout, {8'hC3, tag, 12'h000, 4'(wr_cnt)});
                check(bus_addr == exp_waddr, "R10 write beat address", bus_addr, exp_waddr);
                check(bus_doe == 1'b1, "R5 data driven at strobe release", bus_doe, 1);
                exp_waddr = exp_waddr + 20'd4;
                wr_cnt++;
            end
            prev_rv = rd_valid;
            prev_we = bus_we_n;
        end
    end

    task automatic issue(input logic w, input logic [19:0] a, input logic [2:0] len);
        while (!req_ready) @(negedge clk);
        req_write = w;
        req_addr  = a;
        req_len   = len;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        exp_raddr = a;
        exp_waddr = a;
        rd_cnt    = 0;
        wr_cnt    = 0;
        check(req_ready == 1'b0, "R11 ready low while busy", req_ready, 0);
        check(bus_ce_n == 1'b0, "R10 chip enable low after accept", bus_ce_n, 0);
    endtask

    task automatic pulse1();
        bus_ack_n = 1'b0;
        @(negedge clk);
        bus_ack_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(bus_ce_n && bus_oe_n && bus_we_n, "R1 strobes idle high", {bus_ce_n, bus_oe_n, bus_we_n}, 7);
        check(!bus_doe && !rd_valid, "R1 no drive, no valid", {bus_doe, rd_valid}, 0);
        check(req_ready, "R1 ready after reset", req_ready, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2/R3 single read timing
        issue(1'b0, 20'h01230, 3'd0);
        repeat (2) @(negedge clk);
        bus_ack_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk) bus_ack_n = 1'b1;
        @(posedge clk);
        @(negedge clk) check(rd_valid == 1'b0, "R2 read not due before 4th edge", rd_valid, 0);
        @(posedge clk);
        @(negedge clk);
        check(rd_valid == 1'b1, "R2 R3 read valid at 4th edge", rd_valid, 1);
        check(bus_ce_n == 1'b1, "R10 ce released after single read", bus_ce_n, 1);
        @(negedge clk) check(rd_valid == 1'b0, "R3 valid lasts one cycle", rd_valid, 0);

        // R4/R5 single write timing
        tag = 8'h01;
        issue(1'b1, 20'h00400, 3'd0);
        repeat (2) @(negedge clk);
        bus_ack_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk) bus_ack_n = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) check(bus_we_n == 1'b0, "R4 strobe still low at 4th edge", bus_we_n, 0);
        @(posedge clk);
        @(negedge clk);
        check(bus_we_n == 1'b1, "R4 strobe released at 5th edge", bus_we_n, 1);
        check(bus_doe == 1'b1, "R5 data held one more cycle", bus_doe, 1);
        @(posedge clk);
        @(negedge clk);
        check(bus_doe == 1'b0, "R5 drive off after hold", bus_doe, 0);
        check(bus_ce_n == 1'b1, "R10 ce released after single write", bus_ce_n, 1);
        check(req_ready == 1'b1, "R11 ready again", req_ready, 1);

        // burst sweep, one short acknowledge per beat
        for (int w = 0; w < 2; w++) begin
            for (int len = 0; len < 8; len++) begin
                logic [19:0] base;
                base = 20'h10000 + 20'(len * 64) + 20'(w * 1024);
                tag  = 8'(len + 16 * w);
                issue(w[0], base, 3'(len));
                for (int b = 0; b <= len; b++) begin
                    repeat (2) @(negedge clk);
                    pulse1();
                    repeat (4) @(negedge clk);
                end
                repeat (2) @(negedge clk);
                check(req_ready == 1'b1, "R11 ready after burst", req_ready, 1);
                check((w == 1 ? wr_cnt : rd_cnt) == len + 1, "R10 beat count of burst",
                      (w == 1 ? wr_cnt : rd_cnt), len + 1);
                check(bus_addr == base + 20'(4 * len), "R10 last beat address", bus_addr, base + 20'(4 * len));
            end
        end

        // held acknowledge sweep: R7 reads, R8 writes
        for (int w = 0; w < 2; w++) begin
            for (int h = 1; h <= 12; h++) begin
                int lim, expn, got;
                lim  = (w == 1) ? 5 : 3;
                expn = 1 + (h - 1) / lim;
                if (expn > 8) expn = 8;
                tag = 8'(8'h80 + h);
                issue(w[0], 20'h40000 + 20'(h * 256), 3'd7);
                repeat (2) @(negedge clk);
                bus_ack_n = 1'b0;
                repeat (h) @(negedge clk);
                bus_ack_n = 1'b1;
                repeat (8) @(negedge clk);
                got = (w == 1) ? wr_cnt : rd_cnt;
                check(got == expn, (w == 1) ? "R8 held write ack beats" : "R7 held read ack beats", got, expn);
                while (!req_ready) begin
                    pulse1();
                    repeat (6) @(negedge clk);
                end
                got = (w == 1) ? wr_cnt : rd_cnt;
                check(got == 8, (w == 1) ? "R8 burst completes" : "R7 burst completes", got, 8);
            end
        end

        // R9 acknowledge held from before the request does not end beat 0
        bus_ack_n = 1'b0;
        repeat (3) @(negedge clk);
        issue(1'b0, 20'h02000, 3'd0);
        repeat (12) @(negedge clk);
        check(rd_cnt == 0, "R9 stale ack ignored", rd_cnt, 0);
        check(req_ready == 1'b0, "R9 access still open", req_ready, 0);
        bus_ack_n = 1'b1;
        repeat (3) @(negedge clk);
        pulse1();
        repeat (6) @(negedge clk);
        check(rd_cnt == 1, "R9 fresh ack ends beat", rd_cnt, 1);
        check(req_ready == 1'b1, "R9 idle after fresh ack", req_ready, 1);

        // R9 ack held across ce deassertion into a second request
        issue(1'b0, 20'h03000, 3'd0);
        repeat (2) @(negedge clk);
        bus_ack_n = 1'b0;
        repeat (6) @(negedge clk);
        check(rd_cnt == 1 && req_ready, "R9 first access done under held ack", rd_cnt, 1);
        issue(1'b0, 20'h03100, 3'd0);
        repeat (10) @(negedge clk);
        check(rd_cnt == 0, "R9 held ack gives no spurious beat", rd_cnt, 0);
        bus_ack_n = 1'b1;
        repeat (3) @(negedge clk);
        pulse1();
        repeat (6) @(negedge clk);
        check(rd_cnt == 1, "R9 second access ends on new ack", rd_cnt, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule